// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block is a register-mapped read engine for a one-time-programmable fuse array of 1024 bytes (8192 bits, split into fixed-size regions that are not the concern of the reader). Software sets up the access timing in a configuration register. It then writes a byte address, a byte count and a read request into a control register. The sequencer fetches the bytes one at a time from the fuse macro and drives the macro's address and strobe lines with cycle-exact setup and pulse phases. The bytes fill a bank of eight 32-bit result registers.

When the last byte is captured, a done flag in the status register is set and stays set. If enabled, an interrupt line rises with it. A request covers up to 32 bytes inside one 32-byte-aligned window of the array. The fields that belong to fuse programming are held in the registers but start no activity. The fuse macro answers combinationally with the byte at the address presented.

Top module: `fuse_read_engine`

## Requirements
- R1: Registers are 32 bits wide on a 4-byte stride: control at offset 0x0, configuration at 0x4, status at 0x8, and result word n (n = 0..7) at 0xC + 4n. Result words are read-only. Offsets that are not mapped read as zero.
- R2: The control register holds the start byte address in bits 30:21, the byte count minus one in bits 20:16, a program request in bit 15, a write request in bit 1 and the read request in bit 0. The program and write bits read back as written and never pulse the fuse strobe or change the status.
- R3: The configuration register holds interrupt enable in bit 31, read setup count in bits 23:20, read pulse count in bits 19:16, write setup count in bits 15:12 and write pulse count in bits 11:0. Bits 30:24 read as zero.
- R4: For each byte, the fuse address is presented with strobe low for (setup+1) cycles, then strobe is high for (pulse+4) cycles, and the byte is sampled at the end of the pulse. Each byte therefore costs setup+5+pulse cycles, and done rises count*(setup+5+pulse) cycles after the clock edge that accepts the request.
- R5: Byte i (i = 0..count-1) is fetched from fuse address {start[9:5], i[4:0]}. The low five bits of the start address are ignored, and bytes are fetched in increasing order.
- R6: Result packing is little-endian. Byte i lands in bits 8(i mod 4)+7 : 8(i mod 4) of result word i/4. Bytes at or beyond the count read as zero.
- R7: Status bit 0 is read-done and bit 1 is write-done, which always reads 0. Accepting a read request clears read-done on the same edge. Control bit 0 reads 1 while the read runs and clears when done is set. Done then holds until the next accepted request.
- R8: With interrupt enable set, the irq output rises on the same edge as read-done. It falls when the next request is accepted. With the enable clear, irq stays low.
- R9: A control write that arrives while a read is running is ignored completely: the running read, its timing, its results and the stored control fields are unchanged.
- R10: After reset, every register reads zero, strobe is low and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access select |
| busWe | input | 1 | Write qualifier for a selected access |
| busAddr | input | 6 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| fuseAddr | output | 10 | Byte address to the fuse macro |
| fuseStrobe | output | 1 | Read strobe to the fuse macro |
| fuseRdata | input | 8 | Byte returned by the fuse macro |
| irq | output | 1 | Read-complete interrupt |

## Verification
The read sequence is exercised with a zero setup and pulse count and a full 32-byte window, with a mid-range setting on a short unaligned request, and with both counts at their maximum on a single byte. Against a per-cycle reference, the first case separates an off-by-one in the phase counters, the second separates alignment and zero-fill errors from packing errors, and the third exposes counters that are too narrow. Separate patterns write only the program and write bits, and write a control word in the middle of a running read. These show whether a non-read request, or a request during a busy read, has any effect on the fuse pins, the results or the stored fields.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SETUP = 2'd1,
    SEQ_PULSE = 2'd2
  } seqState_t;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic capture;  // sample fuse byte this edge
    logic finish;   // last byte of the request is being sampled
  } seqStrobe_t;

endpackage

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 5,
  parameter int ADJ_W  = 4,
  parameter int STR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [ADJ_W-1:0]  setupCnt,
  input  logic [STR_W-1:0]  pulseCnt,
  input  logic [IDX_W-1:0]  lastIdx,
  input  logic [ADDR_W-IDX_W-1:0] baseHi,
  output logic              busy,
  output logic [ADDR_W-1:0] fuseAddr,
  output logic              fuseStrobe,
  output seqStrobe_t        strobes
);

  localparam int CNT_W = ((ADJ_W > STR_W) ? ADJ_W : STR_W) + 3;

  seqState_t         state;
  logic [CNT_W-1:0]  phaseCnt;
  logic [IDX_W-1:0]  byteIdx;
  logic [CNT_W-1:0]  setupLast;
  logic [CNT_W-1:0]  pulseLast;
  logic              setupEnd;
  logic              pulseEnd;

  assign setupLast = CNT_W'(setupCnt);
  assign pulseLast = CNT_W'(pulseCnt) + CNT_W'(3);
  assign setupEnd  = (state == SEQ_SETUP) && (phaseCnt == setupLast);
  assign pulseEnd  = (state == SEQ_PULSE) && (phaseCnt == pulseLast);

  assign strobes.capture = pulseEnd;
  assign strobes.finish  = pulseEnd && (byteIdx == lastIdx);

  assign busy       = (state != SEQ_IDLE);
  assign fuseStrobe = (state == SEQ_PULSE);
  assign fuseAddr   = {baseHi, byteIdx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      phaseCnt <= '0;
      byteIdx  <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (startReq) begin
            state    <= SEQ_SETUP;
            phaseCnt <= '0;
            byteIdx  <= '0;
          end
        end
        SEQ_SETUP: begin
          if (setupEnd) begin
            state    <= SEQ_PULSE;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        SEQ_PULSE: begin
          if (pulseEnd) begin
            phaseCnt <= '0;
            if (byteIdx == lastIdx) begin
              state <= SEQ_IDLE;
            end else begin
              state   <= SEQ_SETUP;
              byteIdx <= byteIdx + 1'b1;
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int IDX_W      = 5,
  parameter int DATA_WORDS = 8,
  parameter int ADJ_W      = 4,
  parameter int STR_W      = 4,
  parameter int WADJ_W     = 4,
  parameter int WSTR_W     = 12,
  parameter int BUS_AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              busy,
  input  seqStrobe_t        strobes,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [7:0]        fuseRdata,
  output logic              startReq,
  output logic [ADJ_W-1:0]  setupCnt,
  output logic [STR_W-1:0]  pulseCnt,
  output logic [IDX_W-1:0]  lastIdx,
  output logic [ADDR_W-IDX_W-1:0] baseHi,
  output logic              rdDone,
  output logic              irq
);

  localparam int RIDX_W     = BUS_AW - 2;
  localparam int ADDR_LSB   = 21;
  localparam int LEN_LSB    = 16;
  localparam int PG_BIT     = 15;
  localparam int WR_BIT     = 1;
  localparam int IE_BIT     = 31;
  localparam int RADJ_LSB   = 20;
  localparam int RSTR_LSB   = 16;
  localparam int WADJ_LSB   = 12;
  localparam int DATA_FIRST = 3;

  logic [ADDR_W-1:0] ctlAddr;
  logic [IDX_W-1:0]  ctlLen;
  logic              ctlPg, ctlWr, ctlRd;
  logic              cfgIe;
  logic [ADJ_W-1:0]  cfgRdAdj;
  logic [STR_W-1:0]  cfgRdStr;
  logic [WADJ_W-1:0] cfgWrAdj;
  logic [WSTR_W-1:0] cfgWrStr;

  logic [RIDX_W-1:0] regIdx;
  logic              ctlWrite, cfgWrite;
  logic [DATA_WORDS*32-1:0] bankFlat;

  assign regIdx   = busAddr[BUS_AW-1:2];
  assign ctlWrite = busSel && busWe && (regIdx == RIDX_W'(0)) && !busy;
  assign cfgWrite = busSel && busWe && (regIdx == RIDX_W'(1));
  assign startReq = ctlWrite && busWdata[0];

  assign setupCnt = cfgRdAdj;
  assign pulseCnt = cfgRdStr;
  assign lastIdx  = ctlLen;
  assign baseHi   = ctlAddr[ADDR_W-1:IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctlAddr <= '0;
      ctlLen  <= '0;
      ctlPg   <= 1'b0;
      ctlWr   <= 1'b0;
      ctlRd   <= 1'b0;
    end else if (ctlWrite) begin
      ctlAddr <= busWdata[ADDR_LSB +: ADDR_W];
      ctlLen  <= busWdata[LEN_LSB +: IDX_W];
      ctlPg   <= busWdata[PG_BIT];
      ctlWr   <= busWdata[WR_BIT];
      ctlRd   <= busWdata[0];
    end else if (strobes.finish) begin
      ctlRd <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgIe    <= 1'b0;
      cfgRdAdj <= '0;
      cfgRdStr <= '0;
      cfgWrAdj <= '0;
      cfgWrStr <= '0;
    end else if (cfgWrite) begin
      cfgIe    <= busWdata[IE_BIT];
      cfgRdAdj <= busWdata[RADJ_LSB +: ADJ_W];
      cfgRdStr <= busWdata[RSTR_LSB +: STR_W];
      cfgWrAdj <= busWdata[WADJ_LSB +: WADJ_W];
      cfgWrStr <= busWdata[0 +: WSTR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdDone <= 1'b0;
      irq    <= 1'b0;
    end else if (startReq) begin
      rdDone <= 1'b0;
      irq    <= 1'b0;
    end else if (strobes.finish) begin
      rdDone <= 1'b1;
      irq    <= cfgIe;
    end
  end

  for (genvar w = 0; w < DATA_WORDS; w++) begin : g_word
    logic [31:0] wordReg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wordReg <= '0;
      end else if (startReq) begin
        wordReg <= '0;
      end else if (strobes.capture) begin
        for (int l = 0; l < 4; l++) begin
          if (byteIdx == IDX_W'(w * 4 + l)) begin
            wordReg[8*l +: 8] <= fuseRdata;
          end
        end
      end
    end
    assign bankFlat[w*32 +: 32] = wordReg;
  end

  always_comb begin
    busRdata = '0;
    if (regIdx == RIDX_W'(0)) begin
      busRdata[ADDR_LSB +: ADDR_W] = ctlAddr;
      busRdata[LEN_LSB +: IDX_W]   = ctlLen;
      busRdata[PG_BIT]             = ctlPg;
      busRdata[WR_BIT]             = ctlWr;
      busRdata[0]                  = ctlRd;
    end else if (regIdx == RIDX_W'(1)) begin
      busRdata[IE_BIT]               = cfgIe;
      busRdata[RADJ_LSB +: ADJ_W]    = cfgRdAdj;
      busRdata[RSTR_LSB +: STR_W]    = cfgRdStr;
      busRdata[WADJ_LSB +: WADJ_W]   = cfgWrAdj;
      busRdata[0 +: WSTR_W]          = cfgWrStr;
    end else if (regIdx == RIDX_W'(2)) begin
      busRdata[0] = rdDone;
    end else begin
      for (int w = 0; w < DATA_WORDS; w++) begin
        if (regIdx == RIDX_W'(DATA_FIRST + w)) busRdata = bankFlat[w*32 +: 32];
      end
    end
  end

endmodule

// File: rtl/fuse_read_engine.sv
module fuse_read_engine
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_WORDS = 8,
  parameter int ADJ_W      = 4,
  parameter int STR_W      = 4,
  parameter int WADJ_W     = 4,
  parameter int WSTR_W     = 12,
  parameter int BUS_AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [ADDR_W-1:0] fuseAddr,
  output logic              fuseStrobe,
  input  logic [7:0]        fuseRdata,
  output logic              irq
);

  localparam int IDX_W = $clog2(DATA_WORDS * 4);

  seqStrobe_t              strobes;
  logic                    startReq;
  logic                    busy;
  logic                    rdDone;
  logic [ADJ_W-1:0]        setupCnt;
  logic [STR_W-1:0]        pulseCnt;
  logic [IDX_W-1:0]        lastIdx;
  logic [ADDR_W-IDX_W-1:0] baseHi;

  fuse_rd_seq #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ADJ_W(ADJ_W), .STR_W(STR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .startReq(startReq),
    .setupCnt(setupCnt), .pulseCnt(pulseCnt), .lastIdx(lastIdx),
    .baseHi(baseHi), .busy(busy), .fuseAddr(fuseAddr),
    .fuseStrobe(fuseStrobe), .strobes(strobes)
  );

  fuse_rd_regs #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_WORDS(DATA_WORDS),
    .ADJ_W(ADJ_W), .STR_W(STR_W), .WADJ_W(WADJ_W), .WSTR_W(WSTR_W),
    .BUS_AW(BUS_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busy(busy), .strobes(strobes), .byteIdx(fuseAddr[IDX_W-1:0]),
    .fuseRdata(fuseRdata), .startReq(startReq), .setupCnt(setupCnt),
    .pulseCnt(pulseCnt), .lastIdx(lastIdx), .baseHi(baseHi),
    .rdDone(rdDone), .irq(irq)
  );

endmodule

// File: rtl/fuse_read_engine_chk.sv
module fuse_read_engine_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fuseStrobe,
  input logic [ADDR_W-1:0] fuseAddr,
  input logic              irq,
  input logic              rdDone,
  input logic              busy,
  input logic              startReq
);

  // R4
  strobe_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuseStrobe |-> busy);

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fuseStrobe && $past(fuseStrobe)) |-> $stable(fuseAddr));

  // R8
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rdDone);

  // R7
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startReq |=> !rdDone);

  // R7
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdDone && !startReq) |=> rdDone);

  // R7
  done_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdDone |-> !busy);

endmodule

bind fuse_read_engine fuse_read_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fuseStrobe(fuseStrobe), .fuseAddr(fuseAddr),
  .irq(irq), .rdDone(rdDone), .busy(busy), .startReq(startReq)
);

// File: tb/tb_fuse_read_engine.sv
module tb_fuse_read_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [9:0]  fuseAddr;
  logic        fuseStrobe;
  logic [7:0]  fuseRdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] romByte(input logic [9:0] a);
    logic [15:0] v;
    v = 16'(a) * 16'd37 + 16'd11;
    return v[7:0] ^ 8'(a >> 3);
  endfunction

  assign fuseRdata = romByte(fuseAddr);

  fuse_read_engine dut (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .fuseAddr(fuseAddr), .fuseStrobe(fuseStrobe), .fuseRdata(fuseRdata),
    .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  // start a read and compare the fuse pins and done bit every cycle
  task automatic runRead(input int adj, input int str, input int ie,
                         input int addr, input int len);
    int per, nBytes, errs, doneAt;
    logic [31:0] rd;
    logic [9:0] base;
    per = adj + 5 + str;
    nBytes = len + 1;
    errs = 0;
    doneAt = -1;
    base = 10'(addr) & 10'h3E0;
    busWrite(6'h04, (32'(ie) << 31) | (32'(adj) << 20) | (32'(str) << 16));
    busWrite(6'h00, (32'(addr) << 21) | (32'(len) << 16) | 32'h1);
    for (int c = 0; c <= nBytes * per; c++) begin
      logic expStrobe;
      logic [9:0] expAddr;
      busRead(6'h08, rd);
      if (rd[0] && doneAt < 0) doneAt = c;
      if (rd[0] !== (c >= nBytes * per)) errs++;
      expStrobe = (c < nBytes * per) && ((c % per) >= adj + 1);
      if (fuseStrobe !== expStrobe) errs++;
      if (c < nBytes * per) begin
        expAddr = base | 10'(c / per);
        if (fuseAddr !== expAddr) errs++;
      end
      if (c < nBytes * per) @(negedge clk);
    end
    // R4 R5 per-cycle comparison of strobe, address and done
    check("R4", "per-cycle pin/done mismatches", 32'(errs), 32'd0);
    check("R4", "done cycle", 32'(doneAt), 32'(nBytes * per));
    // R6
    for (int n = 0; n < 8; n++) begin
      logic [31:0] exp;
      exp = '0;
      for (int k = 0; k < 4; k++) begin
        if (4 * n + k < nBytes) exp[8*k +: 8] = romByte(base | 10'(4 * n + k));
      end
      busRead(6'(12 + 4 * n), rd);
      check("R6", $sformatf("result word %0d", n), rd, exp);
    end
    // R8
    check("R8", "irq after done", 32'(irq), 32'(ie));
    // R7
    busRead(6'h00, rd);
    check("R7", "read request bit cleared", 32'(rd[0]), 32'd0);
    busRead(6'h08, rd);
    check("R7", "write-done bit", 32'(rd[1]), 32'd0);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    for (int r = 0; r < 11; r++) begin
      busRead(6'(4 * r), rd);
      check("R10", $sformatf("reg %0d after reset", r), rd, 32'd0);
    end
    check("R10", "strobe after reset", 32'(fuseStrobe), 32'd0);
    check("R10", "irq after reset", 32'(irq), 32'd0);

    // R3 configuration field layout
    busWrite(6'h04, 32'hFFFF_FFFF);
    busRead(6'h04, rd);
    check("R3", "config readback all ones", rd, 32'h80FF_FFFF);
    busWrite(6'h04, 32'h0034_5ABC);
    busRead(6'h04, rd);
    check("R3", "config readback pattern", rd, 32'h0034_5ABC);
    // R1 unmapped offset
    busRead(6'h3C, rd);
    check("R1", "unmapped offset", rd, 32'd0);

    // R4 R5 R6 R8 full window, zero counts, no interrupt
    runRead(0, 0, 0, 10'h000, 31);
    // R5 unaligned start, low bits ignored, short count, interrupt
    runRead(3, 2, 1, 10'h3E7, 5);
    // R4 max counts, single byte
    runRead(15, 15, 1, 10'h120, 0);

    // R7 R8 new start clears done and irq on accepting edge
    busWrite(6'h00, (32'h040 << 21) | (32'd1 << 16) | 32'h1);
    busRead(6'h08, rd);
    check("R7", "done cleared by start", 32'(rd[0]), 32'd0);
    check("R8", "irq cleared by start", 32'(irq), 32'd0);
    busRead(6'h00, rd);
    check("R7", "read bit set while running", 32'(rd[0]), 32'd1);

    // R9 control write while busy: ignored
    busWrite(6'h00, (32'h200 << 21) | (32'd31 << 16) | 32'h8003);
    repeat (2 * 35 + 4) @(negedge clk);
    busRead(6'h00, rd);
    check("R9", "control fields unchanged", rd, (32'h040 << 21) | (32'd1 << 16));
    busRead(6'h0C, rd);
    check("R9", "result of first request",
          rd, {16'd0, romByte(10'h041), romByte(10'h040)});
    busRead(6'h08, rd);
    check("R9", "done after first request", 32'(rd[0]), 32'd1);

    // R2 write/program bits stored, no fuse activity
    begin
      int strobes;
      strobes = 0;
      busWrite(6'h00, (32'h155 << 21) | (32'd7 << 16) | 32'h0000_8002);
      for (int c = 0; c < 40; c++) begin
        if (fuseStrobe) strobes++;
        @(negedge clk);
      end
      check("R2", "no strobe on write/program request", 32'(strobes), 32'd0);
      busRead(6'h00, rd);
      check("R2", "control readback", rd, (32'h155 << 21) | (32'd7 << 16) | 32'h0000_8002);
      busRead(6'h08, rd);
      check("R2", "status untouched", rd, 32'd1);
    end

    finished = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule